// File: doc/BRIEF.md
# Second-Order Masked Quadratic Map (Three-Share Domain)

This block evaluates a 4-bit to 4-bit quadratic map on data split into Boolean shares. It protects the evaluation against probing attacks of order two. The unmasked map takes inputs a, b, c and d and gives two linear outputs (x = a, y = b) and two nonlinear outputs (z = a·b ⊕ c, w = a·c ⊕ d). Each input bit arrives as NSH shares, three by default, and their XOR is the real value. Each output bit leaves as NSH shares in the same way.

For each nonlinear output the block forms every pairwise product of the shares of its two multiplied operands. That gives NSH·NSH product shares. The additive operand's share i is folded into product share (i,i). The full product set is masked with fresh random bits, captured in a register, and then folded back to NSH shares by XOR-ing the products that share the same first-operand index. The linear shares are registered alongside, so all four outputs have the same latency of one clock. The random bits are supplied from outside every cycle. Their generation is outside this block.

Top module: `mq_quad_masked`

## Requirements
- R1: A synchronous active-high reset clears every registered share, so in the cycle after reset is seen all output share bits read 0.
- R2: All outputs reflect the inputs and random bits sampled at the previous rising clock edge (one register stage of latency).
- R3: out_x_sh equals in_a_sh share for share, one cycle later.
- R4: out_y_sh equals in_b_sh share for share, one cycle later.
- R5: The XOR of the three out_z_sh bits equals (A & B) ^ C. Here A, B and C are the XORs of the shares of in_a_sh, in_b_sh and in_c_sh, taken from the previous cycle. This holds for every value of the random bits.
- R6: The XOR of the three out_w_sh bits equals (A & C) ^ D, taken from the previous cycle, for every value of the random bits.
- R7: Product share index k = NSH·i + j of z is a_i & b_j, with c_i added when i = j. For k < 8 the share is XORed with rnd_z[k], and share 8 is XORed with the XOR of all of rnd_z. out_z_sh[i] is the XOR of product shares NSH·i to NSH·i+NSH−1.
- R8: w is built the same way as in R7, using operands a and c, additive shares d_i and random bits rnd_w.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_a_sh | input | NSH | Shares of input a |
| in_b_sh | input | NSH | Shares of input b |
| in_c_sh | input | NSH | Shares of input c |
| in_d_sh | input | NSH | Shares of input d |
| rnd_z | input | NSH*NSH-1 | Fresh mask bits for the z product set |
| rnd_w | input | NSH*NSH-1 | Fresh mask bits for the w product set |
| out_x_sh | output | NSH | Shares of x = a |
| out_y_sh | output | NSH | Shares of y = b |
| out_z_sh | output | NSH | Shares of z = a·b ⊕ c |
| out_w_sh | output | NSH | Shares of w = a·c ⊕ d |

## Verification
The assertions assume only that reset is held for at least one edge before checking starts. They place no limit on the share or random-bit values, because correctness must hold for every mask. The stimulus sweeps all 4096 combinations of the twelve input share bits. Each vector is paired with freshly drawn random bits, and reset is asserted again in the middle of the run with non-zero inputs present. Together these cover every unmasked input value under many different sharings and many refresh patterns.

// File: rtl/mq_pkg.sv
package mq_pkg;

    // default number of shares per bit (second-order security)
    localparam int unsigned MQ_SHARES = 3;

    // number of nonlinear outputs formed by the block
    localparam int unsigned MQ_NL_OUTS = 2;

    // identifies which nonlinear output a generate lane builds
    typedef enum logic [0:0] {
        NL_Z = 1'b0,
        NL_W = 1'b1
    } mq_nl_sel_e;

    // flat index of product share (first-operand share i, second-operand share j)
    function automatic int unsigned mq_prod_idx(input int unsigned i,
                                                input int unsigned j,
                                                input int unsigned nsh);
        return i * nsh + j;
    endfunction

    // mask bit count for one product set
    function automatic int unsigned mq_rnd_bits(input int unsigned nsh);
        return nsh * nsh - 1;
    endfunction

endpackage

// File: rtl/mq_cross_prod.sv
module mq_cross_prod #(
    parameter int unsigned NSH = mq_pkg::MQ_SHARES,
    localparam int unsigned NPROD = NSH * NSH
) (
    input  logic [NSH-1:0]   mul_l,
    input  logic [NSH-1:0]   mul_r,
    input  logic [NSH-1:0]   add_t,
    output logic [NPROD-1:0] prod
);
    import mq_pkg::*;

    // every pairwise share product; additive share lands on the diagonal
    for (genvar i = 0; i < NSH; i++) begin : g_row
        for (genvar j = 0; j < NSH; j++) begin : g_col
            if (i == j) begin : g_diag
                assign prod[mq_prod_idx(i, j, NSH)] = (mul_l[i] & mul_r[j]) ^ add_t[i];
            end else begin : g_off
                assign prod[mq_prod_idx(i, j, NSH)] = mul_l[i] & mul_r[j];
            end
        end
    end

endmodule

// File: rtl/mq_refresh.sv
module mq_refresh #(
    parameter int unsigned NSH = mq_pkg::MQ_SHARES,
    localparam int unsigned NPROD = NSH * NSH,
    localparam int unsigned NRND = NPROD - 1
) (
    input  logic [NPROD-1:0] raw,
    input  logic [NRND-1:0]  rnd,
    output logic [NPROD-1:0] fresh
);
    logic rnd_fold;

    // last share absorbs all masks so the set sum is unchanged
    assign rnd_fold = ^rnd;

    for (genvar k = 0; k < NPROD; k++) begin : g_share
        if (k < NRND) begin : g_single
            assign fresh[k] = raw[k] ^ rnd[k];
        end else begin : g_closing
            assign fresh[k] = raw[k] ^ rnd_fold;
        end
    end

endmodule

// File: rtl/mq_compress.sv
module mq_compress #(
    parameter int unsigned NSH = mq_pkg::MQ_SHARES,
    localparam int unsigned NPROD = NSH * NSH
) (
    input  logic [NPROD-1:0] prod_q,
    output logic [NSH-1:0]   folded
);
    // products sharing a first-operand index are folded together
    for (genvar i = 0; i < NSH; i++) begin : g_group
        assign folded[i] = ^prod_q[i*NSH +: NSH];
    end

endmodule

// File: rtl/mq_quad_masked.sv
module mq_quad_masked #(
    parameter int unsigned NSH = mq_pkg::MQ_SHARES,
    localparam int unsigned NPROD = NSH * NSH,
    localparam int unsigned NRND = NPROD - 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSH-1:0]  in_a_sh,
    input  logic [NSH-1:0]  in_b_sh,
    input  logic [NSH-1:0]  in_c_sh,
    input  logic [NSH-1:0]  in_d_sh,
    input  logic [NRND-1:0] rnd_z,
    input  logic [NRND-1:0] rnd_w,
    output logic [NSH-1:0]  out_x_sh,
    output logic [NSH-1:0]  out_y_sh,
    output logic [NSH-1:0]  out_z_sh,
    output logic [NSH-1:0]  out_w_sh
);
    import mq_pkg::*;

    localparam int unsigned NL = MQ_NL_OUTS;

    // per-lane operand routing
    logic [NSH-1:0]   op_mul_r [NL];
    logic [NSH-1:0]   op_add   [NL];
    logic [NRND-1:0]  op_rnd   [NL];
    logic [NPROD-1:0] prod_raw [NL];
    logic [NPROD-1:0] prod_frs [NL];
    logic [NPROD-1:0] prod_q   [NL];
    logic [NSH-1:0]   nl_out   [NL];

    // registered linear shares
    logic [NSH-1:0] lin_x_q;
    logic [NSH-1:0] lin_y_q;

    for (genvar g = 0; g < NL; g++) begin : g_nl
        if (mq_nl_sel_e'(g) == NL_Z) begin : g_z
            assign op_mul_r[g] = in_b_sh;
            assign op_add[g]   = in_c_sh;
            assign op_rnd[g]   = rnd_z;
        end else begin : g_w
            assign op_mul_r[g] = in_c_sh;
            assign op_add[g]   = in_d_sh;
            assign op_rnd[g]   = rnd_w;
        end

        mq_cross_prod #(.NSH(NSH)) u_prod (
            .mul_l (in_a_sh),
            .mul_r (op_mul_r[g]),
            .add_t (op_add[g]),
            .prod  (prod_raw[g])
        );

        mq_refresh #(.NSH(NSH)) u_refresh (
            .raw   (prod_raw[g]),
            .rnd   (op_rnd[g]),
            .fresh (prod_frs[g])
        );

        // refreshed product set is the only state for this lane
        always_ff @(posedge clk) begin
            if (rst) begin
                prod_q[g] <= '0;
            end else begin
                prod_q[g] <= prod_frs[g];
            end
        end

        mq_compress #(.NSH(NSH)) u_compress (
            .prod_q (prod_q[g]),
            .folded (nl_out[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lin_x_q <= '0;
            lin_y_q <= '0;
        end else begin
            lin_x_q <= in_a_sh;
            lin_y_q <= in_b_sh;
        end
    end

    assign out_x_sh = lin_x_q;
    assign out_y_sh = lin_y_q;
    assign out_z_sh = nl_out[NL_Z];
    assign out_w_sh = nl_out[NL_W];

endmodule

// File: rtl/mq_quad_checker.sv
module mq_quad_checker #(
    parameter int unsigned NSH = mq_pkg::MQ_SHARES,
    localparam int unsigned NRND = NSH * NSH - 1
) (
    input logic            clk,
    input logic            rst,
    input logic [NSH-1:0]  in_a_sh,
    input logic [NSH-1:0]  in_b_sh,
    input logic [NSH-1:0]  in_c_sh,
    input logic [NSH-1:0]  in_d_sh,
    input logic [NRND-1:0] rnd_z,
    input logic [NRND-1:0] rnd_w,
    input logic [NSH-1:0]  out_x_sh,
    input logic [NSH-1:0]  out_y_sh,
    input logic [NSH-1:0]  out_z_sh,
    input logic [NSH-1:0]  out_w_sh
);
    // R1: cleared state visible right after a reset edge
    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (out_x_sh == '0 && out_y_sh == '0 && out_z_sh == '0 && out_w_sh == '0));

    // R2/R3: linear a-shares appear one cycle later
    assert_x_pass_R3: assert property (@(posedge clk) disable iff (rst)
        !rst |=> out_x_sh == $past(in_a_sh));

    // R2/R4
    assert_y_pass_R4: assert property (@(posedge clk) disable iff (rst)
        !rst |=> out_y_sh == $past(in_b_sh));

    // R5: unmasked z is correct whatever the masks
    assert_z_value_R5: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (^out_z_sh) == $past(((^in_a_sh) & (^in_b_sh)) ^ (^in_c_sh)));

    // R6: unmasked w is correct whatever the masks
    assert_w_value_R6: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (^out_w_sh) == $past(((^in_a_sh) & (^in_c_sh)) ^ (^in_d_sh)));

    // R7: first z share carries a0 times all b, c0 and the first group of masks
    assert_z_share0_R7: assert property (@(posedge clk) disable iff (rst)
        !rst |=> out_z_sh[0] == $past((in_a_sh[0] & (^in_b_sh)) ^ in_c_sh[0] ^ (^rnd_z[NSH-1:0])));

    // R8: same for w
    assert_w_share0_R8: assert property (@(posedge clk) disable iff (rst)
        !rst |=> out_w_sh[0] == $past((in_a_sh[0] & (^in_c_sh)) ^ in_d_sh[0] ^ (^rnd_w[NSH-1:0])));

endmodule

bind mq_quad_masked mq_quad_checker #(.NSH(NSH)) u_checker (
    .clk      (clk),
    .rst      (rst),
    .in_a_sh  (in_a_sh),
    .in_b_sh  (in_b_sh),
    .in_c_sh  (in_c_sh),
    .in_d_sh  (in_d_sh),
    .rnd_z    (rnd_z),
    .rnd_w    (rnd_w),
    .out_x_sh (out_x_sh),
    .out_y_sh (out_y_sh),
    .out_z_sh (out_z_sh),
    .out_w_sh (out_w_sh)
);

// File: tb/tb_mq_quad_masked.sv
`timescale 1ns/1ps
module tb_mq_quad_masked;
    localparam int NSH  = 3;
    localparam int NP   = NSH * NSH;
    localparam int NR   = NP - 1;
    localparam int WDOG = 100000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NSH-1:0] a_s = '0, b_s = '0, c_s = '0, d_s = '0;
    logic [NR-1:0]  rz = '0, rw = '0;
    logic [NSH-1:0] x_s, y_s, z_s, w_s;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    mq_quad_masked #(.NSH(NSH)) dut (
        .clk(clk), .rst(rst),
        .in_a_sh(a_s), .in_b_sh(b_s), .in_c_sh(c_s), .in_d_sh(d_s),
        .rnd_z(rz), .rnd_w(rw),
        .out_x_sh(x_s), .out_y_sh(y_s), .out_z_sh(z_s), .out_w_sh(w_s)
    );

    task automatic check(input string req, input logic [NSH-1:0] act, input logic [NSH-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    // expected share vector from the requirement's product/mask definition
    function automatic logic [NSH-1:0] exp_shares(input logic [NSH-1:0] l, input logic [NSH-1:0] r,
                                                 input logic [NSH-1:0] t, input logic [NR-1:0] m);
        logic [NSH-1:0] res;
        logic all_m;
        all_m = 1'b0;
        for (int k = 0; k < NR; k++) all_m ^= m[k];
        for (int i = 0; i < NSH; i++) begin
            res[i] = 1'b0;
            for (int j = 0; j < NSH; j++) begin
                int k;
                logic p;
                k = i * NSH + j;
                p = l[i] & r[j];
                if (i == j) p ^= t[i];
                p ^= (k < NR) ? m[k] : all_m;
                res[i] ^= p;
            end
        end
        return res;
    endfunction

    task automatic apply_and_check(input logic [4*NSH-1:0] v);
        logic [NSH-1:0] ea, eb, ec, ed;
        logic [NR-1:0] ez, ew;
        logic av, bv, cv, dv;
        @(negedge clk);
        {d_s, c_s, b_s, a_s} = v;
        rz = NR'($urandom);
        rw = NR'($urandom);
        ea = a_s; eb = b_s; ec = c_s; ed = d_s; ez = rz; ew = rw;
        @(posedge clk);
        #1;
        av = ^ea; bv = ^eb; cv = ^ec; dv = ^ed;
        check("R3 x shares", x_s, ea);
        check("R4 y shares", y_s, eb);
        check("R5 z unmasked", {{(NSH-1){1'b0}}, ^z_s}, {{(NSH-1){1'b0}}, (av & bv) ^ cv});
        check("R6 w unmasked", {{(NSH-1){1'b0}}, ^w_s}, {{(NSH-1){1'b0}}, (av & cv) ^ dv});
        check("R7 z shares", z_s, exp_shares(ea, eb, ec, ez));
        check("R8 w shares", w_s, exp_shares(ea, ec, ed, ew));
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (WDOG) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        // R1: reset with non-zero inputs present
        a_s = '1; b_s = '1; c_s = '1; d_s = '1; rz = '1; rw = '1;
        repeat (3) @(posedge clk);
        #1;
        check("R1 x after reset", x_s, '0);
        check("R1 y after reset", y_s, '0);
        check("R1 z after reset", z_s, '0);
        check("R1 w after reset", w_s, '0);
        @(negedge clk);
        rst = 1'b0;

        // R2..R8: exhaustive sweep of all share combinations
        for (int v = 0; v < (1 << (4*NSH)); v++) begin
            apply_and_check((4*NSH)'(v));
            if (v == 2000) begin
                // R1: mid-run reset clears live state
                @(negedge clk);
                rst = 1'b1;
                a_s = 3'b101; b_s = 3'b011; c_s = 3'b110; d_s = 3'b111;
                @(posedge clk);
                #1;
                check("R1 x mid-run reset", x_s, '0);
                check("R1 y mid-run reset", y_s, '0);
                check("R1 z mid-run reset", z_s, '0);
                check("R1 w mid-run reset", w_s, '0);
                @(negedge clk);
                rst = 1'b0;
            end
        end

        // R2: output holds one cycle, then follows the new vector
        apply_and_check({3'b001, 3'b010, 3'b100, 3'b111});
        apply_and_check({3'b000, 3'b000, 3'b000, 3'b000});

        done = 1'b1;
        summary();
        $finish;
    end
endmodule